// File: doc/BRIEF.md
# Event Blanking Timer

The block sits behind a divided tachometer event strobe and in front of a capture unit. When an event arrives and no blanking window is open, the block forwards the event and loads a down-counter from a programmable period register. The counter steps down once per count-enable tick. Until it reaches zero, further events are held back from the output.

Each event that is held back sets a sticky detect flag. Software clears this flag with a clear input. The period register can be written at any time. A write made while a window is open leaves that window unchanged, and the new value takes effect at the next load.

All outputs are registered. An event presented on `evt_in` in cycle n shows up on `evt_out` in cycle n+1.

Top module: `blank_timer`

## Requirements
- R1: An event that arrives while the counter is zero loads the counter with the stored period. If the period register is written in the same cycle, the load uses the value held before that write.
- R2: An event that arrives while the counter is zero appears on `evt_out` as a one-cycle pulse in the following cycle. `evt_out` is never high in a cycle that does not follow an accepted event.
- R3: An event that arrives while the counter is non-zero does not reach `evt_out`.
- R4: An event that arrives while the counter is non-zero sets `det_flag` in the following cycle.
- R5: While the counter is non-zero, each cycle with `tick_en` high lowers it by one. After a period P is loaded, the window stays open until exactly P ticks have been counted. The next event after that passes.
- R6: A stored period of zero opens no window. Every event is forwarded and `det_flag` never sets.
- R7: Writing the period register while a window is open does not change the length of that window. The written value sets the length of the next window.
- R8: `det_flag` stays high until a cycle with `clr_flag` high and no blocked event; it is low in the cycle after that. If a clear and a blocked event occur in the same cycle, the flag stays high.
- R9: Synchronous reset clears the counter, the flag, the output and the period register. After reset, events pass unmasked.
- R10: `tick_en` has no effect while the counter is zero. An event that follows idle ticks still passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable tick for the blanking counter |
| evt_in | input | 1 | Divided event strobe, one cycle per event |
| per_wr | input | 1 | Write strobe for the period register |
| per_wdata | input | PERIOD_W | Value written to the period register |
| clr_flag | input | 1 | Clears the detect flag |
| evt_out | output | 1 | Registered, blanked event strobe toward the capture unit |
| det_flag | output | 1 | Sticky flag: an event was blocked |

## Verification
The bench builds the block with `PERIOD_W` = 4. This caps the period at 15 ticks, so the longest window, the zero period and a window of one tick can all be reached in a short run.

The narrow width also means that random writes and random events often land on the boundaries:
- an event in the last cycle of a window,
- a write in the same cycle as a load,
- a clear in the same cycle as a blocked event.

A behavioural model runs in step with the block and compares both outputs on every cycle.

// File: rtl/blank_pkg.sv
package blank_pkg;
  // Outcome of an incoming event in the current cycle
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_PASS = 2'd1,
    EV_HIT  = 2'd2
  } ev_class_e;
endpackage

// File: rtl/blank_gate.sv
module blank_gate
  import blank_pkg::*;
(
  input  logic      evt_in,
  input  logic      active,
  output ev_class_e cls
);
  always_comb begin
    cls = EV_NONE;
    if (evt_in) cls = active ? EV_HIT : EV_PASS;
  end
endmodule

// File: rtl/blank_period_reg.sv
module blank_period_reg #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [PERIOD_W-1:0] wdata,
  output logic [PERIOD_W-1:0] per_q
);
  always_ff @(posedge clk) begin
    if (rst)     per_q <= '0;
    else if (wr) per_q <= wdata;
  end
endmodule

// File: rtl/blank_counter.sv
module blank_counter
  import blank_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  ev_class_e           cls,
  input  logic [PERIOD_W-1:0] load_val,
  output logic [PERIOD_W-1:0] cnt_q,
  output logic                active
);
  localparam logic [PERIOD_W-1:0] ONE = {{(PERIOD_W-1){1'b0}}, 1'b1};

  assign active = |cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                   cnt_q <= '0;
    else if (cls == EV_PASS)   cnt_q <= load_val;
    else if (active && tick_en) cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/blank_flag.sv
module blank_flag
  import blank_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ev_class_e cls,
  input  logic      clr,
  output logic      flag_q
);
  always_ff @(posedge clk) begin
    if (rst)                 flag_q <= 1'b0;
    else if (cls == EV_HIT)  flag_q <= 1'b1;
    else if (clr)            flag_q <= 1'b0;
  end
endmodule

// File: rtl/blank_timer.sv
module blank_timer
  import blank_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                evt_in,
  input  logic                per_wr,
  input  logic [PERIOD_W-1:0] per_wdata,
  input  logic                clr_flag,
  output logic                evt_out,
  output logic                det_flag
);
  logic [PERIOD_W-1:0] per_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic                active;
  ev_class_e           cls;

  blank_period_reg #(.PERIOD_W(PERIOD_W)) u_per (
    .clk(clk), .rst(rst), .wr(per_wr), .wdata(per_wdata), .per_q(per_q)
  );

  blank_gate u_gate (
    .evt_in(evt_in), .active(active), .cls(cls)
  );

  blank_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cls(cls),
    .load_val(per_q), .cnt_q(cnt_q), .active(active)
  );

  blank_flag u_flag (
    .clk(clk), .rst(rst), .cls(cls), .clr(clr_flag), .flag_q(det_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) evt_out <= 1'b0;
    else     evt_out <= (cls == EV_PASS);
  end
endmodule

// File: rtl/blank_timer_chk.sv
module blank_timer_chk #(
  parameter int PERIOD_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_en,
  input logic                evt_in,
  input logic                per_wr,
  input logic                clr_flag,
  input logic                evt_out,
  input logic                det_flag,
  input logic [PERIOD_W-1:0] cnt,
  input logic [PERIOD_W-1:0] per
);
  logic open;
  assign open = (cnt != '0);

  AST_LOAD_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (evt_in && !open) |=> (cnt == $past(per))); // R1
  AST_PASS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (evt_in && !open) |=> evt_out); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !evt_in |=> !evt_out); // R2
  AST_BLOCK_MASKED: assert property (@(posedge clk) disable iff (rst)
    (evt_in && open) |=> !evt_out); // R3
  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (evt_in && open) |=> det_flag); // R4
  AST_TICK_DOWN: assert property (@(posedge clk) disable iff (rst)
    (open && tick_en && !evt_in) |=> (cnt == $past(cnt) - 1'b1)); // R5
  AST_WRITE_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (open && per_wr && !tick_en) |=> $stable(cnt)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (det_flag && !clr_flag) |=> det_flag); // R8
  AST_IDLE_TICK: assert property (@(posedge clk) disable iff (rst)
    (!open && !evt_in) |=> (cnt == '0)); // R10
endmodule

bind blank_timer blank_timer_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .evt_in(evt_in),
  .per_wr(per_wr), .clr_flag(clr_flag), .evt_out(evt_out),
  .det_flag(det_flag), .cnt(cnt_q), .per(per_q)
);

// File: tb/blank_timer_test.sv
module blank_timer_test;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0, evt_in = 1'b0, per_wr = 1'b0, clr_flag = 1'b0;
  logic [PW-1:0] per_wdata = '0;
  logic          evt_out, det_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  int m_cnt = 0, m_per = 0;
  bit m_flag = 0, m_out = 0;

  always #10 clk = ~clk;

  blank_timer #(.PERIOD_W(PW)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .evt_in(evt_in),
    .per_wr(per_wr), .per_wdata(per_wdata), .clr_flag(clr_flag),
    .evt_out(evt_out), .det_flag(det_flag)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_per = 0; m_flag = 0; m_out = 0;
    end else begin
      m_out  = evt_in && (m_cnt == 0);
      m_flag = (evt_in && m_cnt != 0) || (m_flag && !clr_flag);
      if (evt_in && m_cnt == 0)        m_cnt = m_per;
      else if (m_cnt != 0 && tick_en)  m_cnt = m_cnt - 1;
      if (per_wr) m_per = int'(per_wdata);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // drive one cycle of inputs, then compare against the model
  task automatic cyc(input bit e, input bit t, input bit w, input int d, input bit c);
    evt_in = e; tick_en = t; per_wr = w; per_wdata = PW'(d); clr_flag = c;
    @(negedge clk);
    chk("R2 evt_out vs model", evt_out, m_out);
    chk("R4 det_flag vs model", det_flag, m_flag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    evt_in = 0; tick_en = 0; per_wr = 0; clr_flag = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    cyc(0,0,0,0,0);
    chk("R9 out after reset", evt_out, 1'b0);
    chk("R9 flag after reset", det_flag, 1'b0);
    cyc(1,0,0,0,0);
    chk("R9 unmasked after reset", evt_out, 1'b1);
    cyc(1,0,0,0,0);
    chk("R6 zero period passes", evt_out, 1'b1);
    chk("R6 zero period no flag", det_flag, 1'b0);

    // period 3
    cyc(0,0,1,3,0);
    cyc(1,0,0,0,0);
    chk("R2 idle event forwarded", evt_out, 1'b1);
    cyc(1,0,0,0,0);
    chk("R3 masked event blocked", evt_out, 1'b0);
    chk("R4 masked event flags", det_flag, 1'b1);
    cyc(0,0,0,0,0);
    chk("R2 one-cycle pulse", evt_out, 1'b0);
    cyc(0,0,0,0,1);
    chk("R8 clear drops flag", det_flag, 1'b0);
    cyc(0,1,0,0,0);
    cyc(0,1,0,0,0);
    cyc(1,0,0,0,1);
    chk("R5 blocked after two of three ticks", evt_out, 1'b0);
    chk("R8 clear with hit keeps flag", det_flag, 1'b1);
    cyc(0,1,0,0,1);
    cyc(1,0,0,0,0);
    chk("R5 passes after three ticks", evt_out, 1'b1);

    // write during window (count now 3)
    cyc(0,0,1,1,0);
    cyc(0,1,0,0,0);
    cyc(0,1,0,0,0);
    cyc(1,0,0,0,0);
    chk("R7 window keeps old length", evt_out, 1'b0);
    cyc(0,1,0,0,0);
    cyc(1,0,0,0,0);
    chk("R7 pass after old window", evt_out, 1'b1);
    cyc(1,0,0,0,0);
    chk("R7 new length masks", evt_out, 1'b0);
    cyc(0,1,0,0,0);
    cyc(0,1,0,0,0);
    cyc(0,1,0,0,0);
    cyc(1,0,0,0,0);
    chk("R10 idle ticks no effect", evt_out, 1'b1);

    // write in same cycle as load (period is 1)
    cyc(0,1,0,0,0);
    cyc(1,0,1,2,0);
    chk("R1 load with write forwarded", evt_out, 1'b1);
    cyc(0,1,0,0,0);
    cyc(1,0,0,0,0);
    chk("R1 load used pre-write value", evt_out, 1'b1);
    cyc(0,1,0,0,0);
    cyc(1,0,0,0,0);
    chk("R1 next load uses new value", evt_out, 1'b0);
    cyc(0,1,0,0,0);

    // longest period
    cyc(0,0,1,15,1);
    cyc(1,0,0,0,0);
    for (int i = 0; i < 14; i++) cyc(0,1,0,0,0);
    cyc(1,0,0,0,0);
    chk("R5 max period still masked", evt_out, 1'b0);
    cyc(0,1,0,0,0);
    cyc(1,0,0,0,0);
    chk("R5 max period ends", evt_out, 1'b1);

    // reset inside an open window
    cyc(1,0,0,0,0);
    do_reset();
    cyc(1,0,0,0,0);
    chk("R9 reset closes window", evt_out, 1'b1);
    chk("R9 reset clears flag", det_flag, 1'b0);

    for (int i = 0; i < 600; i++)
      cyc(($urandom_range(0,2) == 0), ($urandom_range(0,1) == 1),
          ($urandom_range(0,9) == 0), int'($urandom_range(0,15)),
          ($urandom_range(0,7) == 0));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule